// File: doc/BRIEF.md
# Tick-Gated Watchdog Countdown Timer with APB Access

This block is a 32-bit down-counting watchdog timer that sits on an APB slave port. Software programs a reload value, then sets a single enable bit. That bit starts the counter and also unmasks the interrupt. The counter moves only on clock cycles where an external tick strobe is high. The tick source can therefore speed up or slow down at run time, and the count carries on from where it stands.

When the count steps from one to zero, a raw interrupt flag is set. On the next tick the count reloads from the reload value instead of wrapping. A write of any data to the clear register drops the flag and restarts the count. A key register guards the reload, enable and clear registers against stray writes. A build parameter selects a variant in which the enable bit cannot be cleared by software once it has been set.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, LOAD (0x000) and VALUE (0x004) read 0xFFFFFFFF, and CONTROL (0x008), RIS (0x010), MIS (0x014) and LOCK (0xC00) read 0. The irq output is low.
- R2: The port is a zero-wait APB slave: pready is always 1 and pslverr is always 0. Only bit 0 carries data in CONTROL (enable), RIS, MIS and LOCK. INTCLR (0x00C) reads 0. Any unmapped offset reads 0, and a write to it changes nothing.
- R3: While enable is 1, VALUE drops by exactly one on each clock edge where tick_en is high, and holds on edges where tick_en is low. A change of tick spacing in mid-count does not disturb the count.
- R4: While enable is 0, VALUE does not change however many ticks arrive. Clearing enable leaves RIS unchanged.
- R5: A write to LOAD sets both LOAD and VALUE to the written data, whether or not the counter is enabled.
- R6: When an enabled tick moves VALUE from 1 to 0, RIS becomes 1. The next enabled tick reloads VALUE from LOAD instead of wrapping.
- R7: A write of any data to INTCLR clears RIS and reloads VALUE from LOAD. This takes precedence over a tick arriving in the same cycle.
- R8: A write that moves enable from 0 to 1 reloads VALUE from LOAD.
- R9: MIS reads RIS AND enable, and the irq output equals MIS.
- R10: Writing 0x1ACCE551 to LOCK unlocks the block, and writing any other value locks it. LOCK reads 1 while locked. While locked, writes to LOAD, CONTROL and INTCLR are ignored.
- R11: With STICKY_EN=1, once enable is 1, later CONTROL writes are ignored. CONTROL keeps reading 1 and counting continues until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| irq | output | 1 | Masked watchdog interrupt |

## Verification
A bus write to the clear register can land in the same clock cycle as a tick strobe that would carry the count from one to zero. These two updates compete for both the count and the raw flag. The bench provokes the clash by first running the counter down to exactly one. It then holds tick_en high throughout the access phase of a clear write. The access is judged correct only if, afterwards, the count equals the reload value and both RIS and irq read zero, meaning the clear won over both the decrement and the flag set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register byte offsets
    localparam int unsigned OFF_LOAD  = 32'h000;
    localparam int unsigned OFF_VALUE = 32'h004;
    localparam int unsigned OFF_CTRL  = 32'h008;
    localparam int unsigned OFF_CLR   = 32'h00C;
    localparam int unsigned OFF_RIS   = 32'h010;
    localparam int unsigned OFF_MIS   = 32'h014;
    localparam int unsigned OFF_LOCK  = 32'hC00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOAD,
        SEL_VALUE,
        SEL_CTRL,
        SEL_CLR,
        SEL_RIS,
        SEL_MIS,
        SEL_LOCK
    } reg_sel_e;

endpackage

// File: rtl/wdt_apb_dec.sv
module wdt_apb_dec
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] load_q,
    input  logic [DATA_W-1:0] value_q,
    input  logic              en_q,
    input  logic              ris_q,
    input  logic              locked_q,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic [DATA_W-1:0] prdata
);

    localparam logic [DATA_W-2:0] PAD = '0;

    always_comb begin
        if      (paddr == ADDR_W'(OFF_LOAD))  sel = SEL_LOAD;
        else if (paddr == ADDR_W'(OFF_VALUE)) sel = SEL_VALUE;
        else if (paddr == ADDR_W'(OFF_CTRL))  sel = SEL_CTRL;
        else if (paddr == ADDR_W'(OFF_CLR))   sel = SEL_CLR;
        else if (paddr == ADDR_W'(OFF_RIS))   sel = SEL_RIS;
        else if (paddr == ADDR_W'(OFF_MIS))   sel = SEL_MIS;
        else if (paddr == ADDR_W'(OFF_LOCK))  sel = SEL_LOCK;
        else                                  sel = SEL_NONE;
    end

    assign wr_stb = psel && penable && pwrite;

    always_comb begin
        unique case (sel)
            SEL_LOAD:  prdata = load_q;
            SEL_VALUE: prdata = value_q;
            SEL_CTRL:  prdata = {PAD, en_q};
            SEL_RIS:   prdata = {PAD, ris_q};
            SEL_MIS:   prdata = {PAD, ris_q & en_q};
            SEL_LOCK:  prdata = {PAD, locked_q};
            default:   prdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter bit              STICKY_EN  = 1'b0,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_en,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] value_q,
    output logic              en_q,
    output logic              ris_q,
    output logic              locked_q
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] value;
        logic              en;
        logic              ris;
        logic              locked;
    } state_t;

    state_t st_d, st_q;
    logic   ld_w, clr_w, ctl_w, lock_w, ctl_rise;

    always_comb begin
        st_d     = st_q;
        ld_w     = wr_stb && !st_q.locked && (sel == SEL_LOAD);
        clr_w    = wr_stb && !st_q.locked && (sel == SEL_CLR);
        ctl_w    = wr_stb && !st_q.locked && (sel == SEL_CTRL)
                   && !(STICKY_EN && st_q.en);
        lock_w   = wr_stb && (sel == SEL_LOCK);
        ctl_rise = ctl_w && wdata[0] && !st_q.en;

        // tick-driven counting, lowest priority
        if (st_q.en && tick_en) begin
            if (st_q.value == '0) begin
                st_d.value = st_q.load;
            end else begin
                st_d.value = st_q.value - ONE;
                if (st_q.value == ONE) st_d.ris = 1'b1;
            end
        end

        if (ctl_w)    st_d.en    = wdata[0];
        if (ctl_rise) st_d.value = st_q.load;
        if (ld_w) begin
            st_d.load  = wdata;
            st_d.value = wdata;
        end
        if (clr_w) begin
            st_d.ris   = 1'b0;
            st_d.value = st_q.load;
        end
        if (lock_w) st_d.locked = (wdata != UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.load   <= '1;
            st_q.value  <= '1;
            st_q.en     <= 1'b0;
            st_q.ris    <= 1'b0;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_q   = st_q.load;
    assign value_q  = st_q.value;
    assign en_q     = st_q.en;
    assign ris_q    = st_q.ris;
    assign locked_q = st_q.locked;

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && tick_en && st_q.value != '0 && !wr_stb)
        |=> st_q.value == $past(st_q.value) - ONE);

    // R4
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !wr_stb) |=> $stable(st_q.value));

    // R6
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && tick_en && st_q.value == '0 && !wr_stb)
        |=> st_q.value == $past(st_q.load));

    // R7
    clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (!st_q.ris && st_q.value == $past(st_q.load)));

    // R10
    lock_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_LOAD && st_q.locked) |=> $stable(st_q.load));

    generate
        if (STICKY_EN) begin : g_sticky
            // R11
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.en |=> st_q.en);
        end
    endgenerate

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter bit                STICKY_EN  = 1'b0,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr_stb;
    logic [DATA_W-1:0] load_q, value_q;
    logic              en_q, ris_q, locked_q;

    wdt_apb_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .load_q   (load_q),
        .value_q  (value_q),
        .en_q     (en_q),
        .ris_q    (ris_q),
        .locked_q (locked_q),
        .sel      (sel),
        .wr_stb   (wr_stb),
        .prdata   (prdata)
    );

    wdt_core #(.DATA_W(DATA_W), .STICKY_EN(STICKY_EN), .UNLOCK_KEY(UNLOCK_KEY)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .sel      (sel),
        .wdata    (pwdata),
        .tick_en  (tick_en),
        .load_q   (load_q),
        .value_q  (value_q),
        .en_q     (en_q),
        .ris_q    (ris_q),
        .locked_q (locked_q)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq     = ris_q & en_q;

endmodule

// File: tb/tb_tick_watchdog.sv
module tb_tick_watchdog;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTL = 12'h008,
                              A_CLR = 12'h00C, A_RIS = 12'h010, A_MIS = 12'h014,
                              A_LOCK = 12'hC00, A_HOLE = 12'h020;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel_n = 1'b0, psel_s = 1'b0, penable = 1'b0, pwrite = 1'b0, tick_en = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prd_n, prd_s;
    logic rdy_n, err_n, irq_n, rdy_s, err_s, irq_s;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    tick_watchdog #(.STICKY_EN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel_n), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_n), .pready(rdy_n), .pslverr(err_n),
        .tick_en(tick_en), .irq(irq_n));

    tick_watchdog #(.STICKY_EN(1'b1)) dut_sticky (
        .clk(clk), .rst_n(rst_n), .psel(psel_s), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd_s), .pready(rdy_s), .pslverr(err_s),
        .tick_en(tick_en), .irq(irq_s));

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sticky, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit tk = 1'b0);
        @(negedge clk);
        paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
        if (sticky) psel_s = 1'b1; else psel_n = 1'b1;
        @(negedge clk);
        penable = 1'b1; tick_en = tk;
        @(negedge clk);
        psel_n = 1'b0; psel_s = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input bit sticky, input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        paddr = a; pwrite = 1'b0; penable = 1'b0;
        if (sticky) psel_s = 1'b1; else psel_n = 1'b1;
        @(negedge clk);
        penable = 1'b1;
        #1 d = sticky ? prd_s : prd_n;
        @(negedge clk);
        psel_n = 1'b0; psel_s = 1'b0; penable = 1'b0;
    endtask

    task automatic rchk(input bit sticky, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string req);
        logic [DW-1:0] v;
        rd(sticky, a, v);
        chk(req, v, exp);
    endtask

    task automatic ticks(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            for (int j = 1; j < spacing; j++) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rchk(0, A_LOAD, 32'hFFFF_FFFF, "R1 load");
        rchk(0, A_VAL,  32'hFFFF_FFFF, "R1 value");
        rchk(0, A_CTL,  0, "R1 control");
        rchk(0, A_RIS,  0, "R1 ris");
        rchk(0, A_MIS,  0, "R1 mis");
        rchk(0, A_LOCK, 0, "R1 lock");
        chk("R1 irq", {31'b0, irq_n}, 0);
        chk("R2 pready", {31'b0, rdy_n}, 1);
        chk("R2 pslverr", {31'b0, err_n}, 0);
    endtask

    task automatic t_load_hold();
        wr(0, A_LOAD, 4000);
        rchk(0, A_VAL, 4000, "R5 load sets value while off");
        ticks(50, 1);
        rchk(0, A_VAL, 4000, "R4 value frozen while off");
        rchk(0, A_RIS, 0, "R4 ris untouched while off");
    endtask

    task automatic t_count();
        wr(0, A_CTL, 1);
        rchk(0, A_CTL, 1, "R2 control bit0");
        rchk(0, A_VAL, 4000, "R8 value after enable");
        ticks(500, 2);
        rchk(0, A_VAL, 3500, "R3 500 ticks");
        ticks(250, 3);
        ticks(250, 1);
        rchk(0, A_VAL, 3000, "R3 tick spacing change");
        wr(0, A_CTL, 0);
        ticks(100, 1);
        rchk(0, A_VAL, 3000, "R4 disable freezes");
        rchk(0, A_CTL, 0, "R4 control cleared");
        wr(0, A_CTL, 1);
        rchk(0, A_VAL, 4000, "R8 rising enable reloads");
    endtask

    task automatic t_expire();
        wr(0, A_LOAD, 10);
        ticks(9, 1);
        rchk(0, A_VAL, 1, "R6 value one");
        rchk(0, A_RIS, 0, "R6 ris before zero");
        ticks(1, 1);
        rchk(0, A_VAL, 0, "R6 value zero");
        rchk(0, A_RIS, 1, "R6 ris set");
        rchk(0, A_MIS, 1, "R9 mis set");
        chk("R9 irq high", {31'b0, irq_n}, 1);
        ticks(1, 1);
        rchk(0, A_VAL, 10, "R6 reload not wrap");
        wr(0, A_CTL, 0);
        rchk(0, A_MIS, 0, "R9 mis masked");
        chk("R9 irq masked", {31'b0, irq_n}, 0);
        rchk(0, A_RIS, 1, "R4 ris kept on disable");
        wr(0, A_CTL, 1);
        rchk(0, A_VAL, 10, "R8 reload again");
    endtask

    task automatic t_clear();
        ticks(3, 1);
        rchk(0, A_VAL, 7, "R3 count after reenable");
        wr(0, A_CLR, 32'hDEAD_BEEF);
        rchk(0, A_RIS, 0, "R7 ris cleared");
        rchk(0, A_VAL, 10, "R7 clear reloads");
        ticks(9, 1);
        rchk(0, A_VAL, 1, "R7 setup value one");
        wr(0, A_CLR, 0, 1'b1);
        rchk(0, A_VAL, 10, "R7 clear beats tick value");
        rchk(0, A_RIS, 0, "R7 clear beats tick ris");
        chk("R7 irq low after clash", {31'b0, irq_n}, 0);
    endtask

    task automatic t_lock();
        ticks(10, 1);
        rchk(0, A_RIS, 1, "R6 ris before lock");
        wr(0, A_LOCK, 32'h1234);
        rchk(0, A_LOCK, 1, "R10 locked reads 1");
        wr(0, A_LOAD, 77);
        rchk(0, A_LOAD, 10, "R10 load ignored");
        rchk(0, A_VAL, 0, "R10 value untouched");
        wr(0, A_CTL, 0);
        rchk(0, A_CTL, 1, "R10 control ignored");
        wr(0, A_CLR, 0);
        rchk(0, A_RIS, 1, "R10 clear ignored");
        wr(0, A_LOCK, 32'h1ACC_E551);
        rchk(0, A_LOCK, 0, "R10 unlocked");
        wr(0, A_LOAD, 77);
        rchk(0, A_VAL, 77, "R10 load after unlock");
    endtask

    task automatic t_unmapped();
        wr(0, A_HOLE, 32'h55);
        rchk(0, A_HOLE, 0, "R2 unmapped reads 0");
        rchk(0, A_LOAD, 77, "R2 unmapped write no effect");
        rchk(0, A_CLR, 0, "R2 clear reads 0");
        chk("R2 pslverr low", {31'b0, err_n}, 0);
    endtask

    task automatic t_sticky();
        rchk(1, A_CTL, 0, "R11 sticky reset");
        wr(1, A_CTL, 1);
        ticks(5, 1);
        rchk(1, A_VAL, 32'hFFFF_FFFA, "R11 sticky counting");
        wr(1, A_CTL, 0);
        rchk(1, A_CTL, 1, "R11 control stays set");
        ticks(5, 2);
        rchk(1, A_VAL, 32'hFFFF_FFF5, "R11 counting continues");
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_hold();
        t_count();
        t_expire();
        t_clear();
        t_lock();
        t_unmapped();
        t_sticky();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule